// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a classic 8-bit microcontroller external memory bus. The first is an active-high address latch strobe. The second is an active-low program fetch read strobe. Both are derived from the oscillator clock and a machine-cycle phase count that the surrounding core supplies. A machine cycle is six states of two oscillator clocks each, and the phase input counts 0 to 11 across it.

The core also supplies four per-cycle qualifiers:
- a flag marking a machine cycle that moves data to or from external data memory;
- a flag marking a code-table read from external program memory;
- a level saying the core is executing from external program memory;
- a software bit that silences the latch strobe.

The block samples these qualifiers when the phase input shows 0, and holds them for the rest of that machine cycle. Both strobes are registered, so each output shows the decode of the phase presented at the previous clock edge.

The latch strobe runs freely at one sixth of the oscillator rate and can be used as a clock. One of its two pulses is dropped in every external data cycle. The fetch strobe pulses twice per machine cycle during external execution, and drops both pulses in an external data cycle.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the block forces `ale_o` to 0 and `psen_no` to 1 after that edge.
- R2: With no qualifiers set, `ale_o` is 1 exactly after the edges at which `phase_i` is 0, 1, 6 or 7. This gives two pulses of two clocks each per 12-clock cycle, which is one sixth of the clock rate.
- R3: In a cycle flagged by `xdata_cyc_i`, the pulse at phases 0 and 1 is omitted and the pulse at phases 6 and 7 is kept.
- R4: With `ext_exec_i` set, `psen_no` is 0 after edges at phases 2 to 5 and 8 to 11, and 1 otherwise. In a cycle flagged by `xdata_cyc_i`, it stays 1 for all 12 phases.
- R5: With `ext_exec_i` clear, `psen_no` stays 1, except in a cycle flagged by `code_rd_cyc_i`. Such a cycle uses the R4 pattern, unless `xdata_cyc_i` is also set, in which case `psen_no` stays 1.
- R6: With `ale_off_i` set, `ext_exec_i` clear and neither cycle flag set, `ale_o` is held at 1 for the whole cycle.
- R7: With `ale_off_i` set, a cycle flagged by `code_rd_cyc_i` or `xdata_cyc_i` shows the normal `ale_o` pattern of R2, with R3 applied in a data cycle.
- R8: While `ext_exec_i` is set, `ale_off_i` has no effect on `ale_o`.
- R9: The qualifiers are taken when `phase_i` is 0. Changes to them during phases 1 to 11 do not affect the outputs until the next phase 0.
- R10: `ale_o` at 1 and `psen_no` at 0 never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| phase_i | input | 4 | Machine-cycle phase, 0 to 11 |
| xdata_cyc_i | input | 1 | Current cycle accesses external data memory |
| code_rd_cyc_i | input | 1 | Current cycle reads a code table from external program memory |
| ext_exec_i | input | 1 | Core executes from external program memory |
| ale_off_i | input | 1 | Software latch-strobe silence bit |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program fetch read strobe, active low |

## Verification
The hardest situation to reach is a cycle whose qualifiers change after phase 0. In that case the outputs must follow the values seen at phase 0 and not the current pins. To reach it, the stimulus presents one qualifier set together with phase 0, then switches to a contrasting set for phases 1 to 11. One case moves from plain external execution to a silenced data cycle. Another moves from a data cycle back to plain execution. Every phase is then compared against the pattern the phase-0 set predicts. The silence bit also needs care: it is combined with each of the two cycle flags and with external execution, so that idle-high, pass-through and ignored behaviour are each observed.

// File: rtl/xbs_pkg.sv
// Shared types for the external bus strobe generator.
// Assumes: no parameters are needed here; widths of the phase count are
// derived in the modules from their own parameters.
package xbs_pkg;

    // Qualifiers that apply to one machine cycle.
    typedef struct packed {
        logic ext_data;   // cycle moves data to/from external data memory
        logic code_rd;    // cycle reads a code table from external program memory
        logic ext_exec;   // core is executing from external program memory
        logic ale_off;    // software silence bit for the latch strobe
    } cyc_flags_t;

    // Phase windows decoded from the machine-cycle phase.
    typedef struct packed {
        logic ale_win;    // phase lies in either latch strobe slot
        logic ale_first;  // phase lies in the first latch strobe slot
        logic psen_win;   // phase lies in either fetch strobe slot
    } win_t;

endpackage

// File: rtl/xbs_phase_decode.sv
// Phase window decoder.
// Decodes the machine-cycle phase into the latch-strobe and fetch-strobe
// windows, and flags the first phase of a cycle.
// Assumes: phase_i counts 0 .. PHASES-1, one step per clock; states are
// numbered from 1, and each state lasts CLKS_PER_STATE clocks.
module xbs_phase_decode
    import xbs_pkg::*;
#(
    parameter int CLKS_PER_STATE = 2,
    parameter int NUM_STATES     = 6,
    parameter int ALE_STATE_A    = 1,
    parameter int ALE_STATE_B    = 4,
    parameter int PSEN_STATE_A   = 2,
    parameter int PSEN_STATE_B   = 5,
    parameter int PSEN_STATES    = 2,
    parameter int PW             = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [PW-1:0] phase_i,
    output win_t          win_o,
    output logic          cyc_start_o
);

    localparam int PHASES   = CLKS_PER_STATE * NUM_STATES;
    localparam int ALE_LEN  = CLKS_PER_STATE;
    localparam int PSEN_LEN = CLKS_PER_STATE * PSEN_STATES;

    int         ph;
    logic [1:0] ale_hit;
    logic [1:0] psen_hit;

    assign ph = int'(phase_i);

    // One window comparator per strobe slot; the two slots differ only in start state.
    for (genvar g = 0; g < 2; g++) begin : g_slot
        localparam int A_START = (((g == 0) ? ALE_STATE_A  : ALE_STATE_B)  - 1) * CLKS_PER_STATE;
        localparam int P_START = (((g == 0) ? PSEN_STATE_A : PSEN_STATE_B) - 1) * CLKS_PER_STATE;
        assign ale_hit[g]  = (ph >= A_START) && (ph < A_START + ALE_LEN);
        assign psen_hit[g] = (ph >= P_START) && (ph < P_START + PSEN_LEN);
    end

    // Combine the slot hits into the window record.
    always_comb begin
        win_o.ale_win   = |ale_hit;
        win_o.ale_first = ale_hit[0];
        win_o.psen_win  = |psen_hit;
        cyc_start_o     = (ph == 0);
    end

    // R2: the phase supplied by the core must stay inside one machine cycle.
    p_phase_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ph < PHASES);

    // R10: the latch slots and the fetch slots never overlap.
    p_slots_disjoint_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(win_o.ale_win && win_o.psen_win));

endmodule

// File: rtl/xbs_flag_latch.sv
// Per-cycle qualifier capture.
// Takes the qualifier inputs when the cycle starts and holds them for the
// remaining phases, so that one machine cycle sees one consistent set.
// Assumes: cyc_start_i is high for exactly the first phase of each cycle.
module xbs_flag_latch
    import xbs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cyc_start_i,
    input  cyc_flags_t flags_i,
    output cyc_flags_t cur_o
);

    cyc_flags_t held_q;

    // Live inputs at the cycle start, held copy for all later phases.
    always_comb begin
        cur_o = cyc_start_i ? flags_i : held_q;
    end

    // Hold register: refreshed from the effective set each clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            held_q <= '0;
        end else begin
            held_q <= cur_o;
        end
    end

    // R9: the qualifiers seen at a cycle start are the ones held afterwards.
    p_capture_at_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_start_i |=> (held_q == $past(flags_i)));

    // R9: no change to the held set except at a cycle start.
    p_hold_midcycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_start_i |=> $stable(held_q));

endmodule

// File: rtl/xbs_strobe_out.sv
// Strobe output stage.
// Combines the phase windows with the qualifiers of the current cycle and
// registers both strobes, so neither output can glitch.
// Assumes: win_i and cyc_i refer to the same phase.
module xbs_strobe_out
    import xbs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  win_t       win_i,
    input  cyc_flags_t cyc_i,
    output logic       ale_o,
    output logic       psen_no
);

    logic silenced;
    logic psen_on;
    logic ale_d;
    logic psen_n_d;

    // Next-state strobe values for the current phase.
    always_comb begin
        // The silence bit counts only for internal execution in a cycle with no external move.
        silenced = cyc_i.ale_off && !cyc_i.ext_exec && !cyc_i.ext_data && !cyc_i.code_rd;
        // Fetch strobe runs for external execution or a table read, never in a data cycle.
        psen_on  = (cyc_i.ext_exec || cyc_i.code_rd) && !cyc_i.ext_data;
        if (silenced) begin
            ale_d = 1'b1;
        end else begin
            ale_d = win_i.ale_win && !(cyc_i.ext_data && win_i.ale_first);
        end
        psen_n_d = !(psen_on && win_i.psen_win);
    end

    // Output registers with synchronous reset to the idle levels.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ale_o   <= 1'b0;
            psen_no <= 1'b1;
        end else begin
            ale_o   <= ale_d;
            psen_no <= psen_n_d;
        end
    end

    // R1: the reset levels appear after the edge at which reset is seen.
    p_reset_levels_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!ale_o && psen_no));

    // R2: a latch pulse that starts lasts at least a second clock.
    p_ale_min_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ale_o) |=> ale_o);

    // R4: a fetch pulse that starts lasts at least a second clock.
    p_psen_min_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(psen_no) |=> !psen_no);

    // R3: the first latch slot of a data cycle produces no pulse.
    p_data_drops_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_i.ext_data && win_i.ale_first) |=> !ale_o);

    // R5: internal execution without a table read leaves the fetch strobe idle.
    p_psen_idle_internal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cyc_i.ext_exec && !cyc_i.code_rd) |=> psen_no);

    // R10: the two strobes are never active together.
    p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ale_o && !psen_no));

endmodule

// File: rtl/xbus_strobe_gen.sv
// External bus strobe generator, top level.
// Produces the address latch strobe and the program fetch read strobe from
// the oscillator clock, the machine-cycle phase and the per-cycle qualifiers.
// Assumes: phase_i is driven by the core's cycle counter, 0 at the first
// clock of each machine cycle; outputs lag the phase by one clock.
module xbus_strobe_gen
    import xbs_pkg::*;
#(
    parameter int CLKS_PER_STATE = 2,
    parameter int NUM_STATES     = 6,
    parameter int ALE_STATE_A    = 1,
    parameter int ALE_STATE_B    = 4,
    parameter int PSEN_STATE_A   = 2,
    parameter int PSEN_STATE_B   = 5,
    parameter int PSEN_STATES    = 2,
    localparam int PHASES        = CLKS_PER_STATE * NUM_STATES,
    localparam int PW            = $clog2(PHASES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [PW-1:0] phase_i,
    input  logic          xdata_cyc_i,
    input  logic          code_rd_cyc_i,
    input  logic          ext_exec_i,
    input  logic          ale_off_i,
    output logic          ale_o,
    output logic          psen_no
);

    win_t       win;
    logic       cyc_start;
    cyc_flags_t flags_in;
    cyc_flags_t cyc_cur;

    // Gather the raw qualifiers into one record.
    always_comb begin
        flags_in.ext_data = xdata_cyc_i;
        flags_in.code_rd  = code_rd_cyc_i;
        flags_in.ext_exec = ext_exec_i;
        flags_in.ale_off  = ale_off_i;
    end

    xbs_phase_decode #(
        .CLKS_PER_STATE (CLKS_PER_STATE),
        .NUM_STATES     (NUM_STATES),
        .ALE_STATE_A    (ALE_STATE_A),
        .ALE_STATE_B    (ALE_STATE_B),
        .PSEN_STATE_A   (PSEN_STATE_A),
        .PSEN_STATE_B   (PSEN_STATE_B),
        .PSEN_STATES    (PSEN_STATES),
        .PW             (PW)
    ) u_decode (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .phase_i     (phase_i),
        .win_o       (win),
        .cyc_start_o (cyc_start)
    );

    xbs_flag_latch u_latch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cyc_start_i (cyc_start),
        .flags_i     (flags_in),
        .cur_o       (cyc_cur)
    );

    xbs_strobe_out u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .win_i   (win),
        .cyc_i   (cyc_cur),
        .ale_o   (ale_o),
        .psen_no (psen_no)
    );

    // R8: during external execution a latch pulse still ends after two clocks.
    p_ext_exec_pulses_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_cur.ext_exec && $rose(ale_o)) |=> ##1 !ale_o);

endmodule

// File: tb/xbus_strobe_gen_bench.sv
// Directed bench: one task per scenario; every phase of every cycle is compared.
module xbus_strobe_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PHASES     = 12;
    localparam int WATCHDOG   = 200000;

    logic       clk;
    logic       rst_n;
    logic [3:0] phase;
    logic       xdata;
    logic       code_rd;
    logic       ext_exec;
    logic       ale_off;
    logic       ale;
    logic       psen_n;

    int  n_checks;
    int  n_errors;
    int  rise_cnt;
    bit  prev_ale;
    bit  done;

    xbus_strobe_gen u_xbus_strobe_gen (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .phase_i       (phase),
        .xdata_cyc_i   (xdata),
        .code_rd_cyc_i (code_rd),
        .ext_exec_i    (ext_exec),
        .ale_off_i     (ale_off),
        .ale_o         (ale),
        .psen_no       (psen_n)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected latch strobe for phase p under a qualifier set (R2, R3, R6, R7, R8).
    function automatic bit exp_ale(int p, bit d, bit c, bit x, bit o);
        if (o && !x && !d && !c) return 1'b1;
        if (d && p < 2) return 1'b0;
        return (p < 2) || (p == 6) || (p == 7);
    endfunction

    // Expected fetch strobe level for phase p (R4, R5).
    function automatic bit exp_psen_n(int p, bit d, bit c, bit x);
        bit on;
        on = (x || c) && !d;
        return !(on && ((p >= 2 && p <= 5) || p >= 8));
    endfunction

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // One machine cycle: set A is applied with phase 0, set B with phases 1..11.
    task automatic run_mc(input bit d0, input bit c0, input bit x0, input bit o0,
                          input bit d1, input bit c1, input bit x1, input bit o1,
                          input string req);
        for (int p = 0; p < PHASES; p++) begin
            @(negedge clk);
            phase    = 4'(p);
            xdata    = (p == 0) ? d0 : d1;
            code_rd  = (p == 0) ? c0 : c1;
            ext_exec = (p == 0) ? x0 : x1;
            ale_off  = (p == 0) ? o0 : o1;
            @(posedge clk);
            #2;
            chk(ale, exp_ale(p, d0, c0, x0, o0), req, $sformatf("ale phase %0d", p));
            chk(psen_n, exp_psen_n(p, d0, c0, x0), req, $sformatf("psen_n phase %0d", p));
            chk(!(ale && !psen_n), 1'b1, "R10", $sformatf("overlap phase %0d", p));
            if (ale && !prev_ale) rise_cnt++;
            prev_ale = ale;
        end
    endtask

    task automatic t_reset();
        // R1: reset held while external execution would otherwise pulse both strobes
        for (int p = 0; p < PHASES; p++) begin
            @(negedge clk);
            phase = 4'(p);
            ext_exec = 1'b1;
            @(posedge clk);
            #2;
            chk(ale, 1'b0, "R1", "ale in reset");
            chk(psen_n, 1'b1, "R1", "psen_n in reset");
        end
        @(negedge clk);
        rst_n = 1'b1;
        phase = 4'd11;
        ext_exec = 1'b0;
        @(posedge clk);
        #2;
        prev_ale = ale;
    endtask

    task automatic t_normal();
        // R2: internal execution, latch strobe free-runs at one sixth of the clock
        rise_cnt = 0;
        run_mc(0,0,0,0, 0,0,0,0, "R2");
        run_mc(0,0,0,0, 0,0,0,0, "R2");
        chk(rise_cnt == 4, 1'b1, "R2", "four latch pulses in 24 clocks");
        // R5: no fetch strobe during internal execution
        run_mc(0,0,0,0, 0,0,0,0, "R5");
    endtask

    task automatic t_ext_exec();
        run_mc(0,0,1,0, 0,0,1,0, "R4");   // R4: two fetch pulses per cycle
        run_mc(1,0,1,0, 1,0,1,0, "R3");   // R3: data cycle drops first latch pulse
        run_mc(1,0,1,0, 1,0,1,0, "R4");   // R4: data cycle drops both fetch pulses
        run_mc(0,0,1,0, 0,0,1,0, "R4");   // back to normal fetches
    endtask

    task automatic t_code_read();
        run_mc(0,1,0,0, 0,1,0,0, "R5");   // R5: table read pulses the fetch strobe
        run_mc(1,1,0,0, 1,1,0,0, "R5");   // R5: data flag overrides the table read
        run_mc(1,0,0,0, 1,0,0,0, "R3");   // R3: internal data cycle
    endtask

    task automatic t_ale_off();
        run_mc(0,0,0,1, 0,0,0,1, "R6");   // R6: silenced, latch held high
        run_mc(0,0,0,1, 0,0,0,1, "R6");
        run_mc(1,0,0,1, 1,0,0,1, "R7");   // R7: data move still strobes
        run_mc(0,1,0,1, 0,1,0,1, "R7");   // R7: table read still strobes
        run_mc(0,0,1,1, 0,0,1,1, "R8");   // R8: bit ignored in external execution
        run_mc(1,0,1,1, 1,0,1,1, "R8");
    endtask

    task automatic t_midcycle();
        run_mc(0,0,1,0, 1,0,0,1, "R9");   // R9: later silence/data flags ignored
        run_mc(1,0,1,0, 0,0,1,0, "R9");   // R9: data cycle kept to its end
        run_mc(0,0,0,1, 0,1,1,0, "R9");   // R9: silence kept despite later flags
        run_mc(0,0,0,0, 0,0,0,0, "R2");   // all quiet again
    endtask

    initial begin
        n_checks = 0;
        n_errors = 0;
        rise_cnt = 0;
        prev_ale = 1'b0;
        done     = 1'b0;
        rst_n    = 1'b0;
        phase    = '0;
        xdata    = 1'b0;
        code_rd  = 1'b0;
        ext_exec = 1'b0;
        ale_off  = 1'b0;
        t_reset();
        t_normal();
        t_ext_exec();
        t_code_read();
        t_ale_off();
        t_midcycle();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

endmodule